// File: doc/BRIEF.md
# Set/Clear Pin Attribute Controller

A 32-pin general purpose I/O controller. The pins are split into two banks of sixteen: a low bank for pins 0 to 15 and a high bank for pins 16 to 31. Each bank holds eight per-pin attribute registers: output value, output enable, open-drain, output invert, pull-up, pull-down, input enable and input invert. Software reaches a high-bank pin at bit position (pin - 16) of the high bank. The high bank's registers are placed 0x80 above the low bank's.

Every attribute register is written in a set/clear format. The lower half of the 32-bit write word names the pins to set, and the upper half names the pins to clear. One bus write therefore changes single pins without a read-modify-write. This makes the update safe against other agents that touch different pins of the same register.

The pad side drives a value, an output enable and pull controls for each pin. It also returns the conditioned input value that the pin presents.

Top module: `gpio_sc_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, every attribute bit is 0. pad_out_o, pad_oe_o, pad_pu_o, pad_pd_o and in_val_o are all 0.
- R2: A write with we_i high sets attribute bit k of the addressed register for each 1 in wdata_i[k] (k = 0..15). The update is visible after the next rising clk_i edge. Bits not named keep their value.
- R3: A 1 in wdata_i[k+16] clears attribute bit k of the addressed register.
- R4: When a write has both wdata_i[k] and wdata_i[k+16] high, bit k ends up cleared.
- R5: addr_i[7] selects the bank: 0 for the low bank (pins 0-15), 1 for the high bank (pin p at bit p-16).
- R6: The offsets within a bank (addr_i[6:0]) are: output value 0x00, output enable 0x04, open-drain 0x08, output invert 0x0C, pull-up 0x18, pull-down 0x1C, input enable 0x20, input invert 0x24. rdata_o shows the 16 bits of the register selected by addr_i in the same cycle, in bits [15:0], and 0 in bits [31:16].
- R7: Writes to any other offset (for example 0x10, 0x30 or 0x40) change no attribute bit. Reads of such an offset return 0.
- R8: A pin with output enable set and open-drain clear has pad_oe_o = 1 and pad_out_o = output value XOR output invert.
- R9: A pin with output enable and open-drain both set has pad_out_o = 0. Its pad_oe_o is 1 exactly when output value XOR output invert is 0.
- R10: A pin with output enable clear has pad_oe_o = 0 and pad_out_o = 0.
- R11: pad_pu_o and pad_pd_o follow the pull-up and pull-down attribute bits of each pin.
- R12: in_val_o for a pin equals pad_in_i XOR input invert when input enable is set, and 0 when input enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Register byte address: bank in bit 7, offset in bits 6:0 |
| wdata_i | input | 32 | Write word: set mask in 15:0, clear mask in 31:16 |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pad_in_i | input | 32 | Level seen at each pad |
| pad_out_o | output | 32 | Value driven on each pad |
| pad_oe_o | output | 32 | Pad driver enable per pin |
| pad_pu_o | output | 32 | Pull-up enable per pin |
| pad_pd_o | output | 32 | Pull-down enable per pin |
| in_val_o | output | 32 | Conditioned input value per pin |

## Verification
Two operations can fall in the same cycle. The first is a set and a clear aimed at one pin. The bench provokes this with a single word that carries both halves for pin 0, then reads the value register back and expects the clear to have taken effect. Other vectors combine a set of one pin with a clear of another, and the result must show both effects and nothing else. The second is the open-drain drive rule meeting the output inversion. It is judged on the pad outputs with open-drain and invert active on neighbouring pins at the same time.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int NATTR  = 8;
  localparam int OFS_W  = 7;

  localparam int A_VAL  = 0;
  localparam int A_OE   = 1;
  localparam int A_OD   = 2;
  localparam int A_OINV = 3;
  localparam int A_PU   = 4;
  localparam int A_PD   = 5;
  localparam int A_IE   = 6;
  localparam int A_IINV = 7;

  // bank-relative byte offset of each attribute register
  function automatic logic [OFS_W-1:0] attr_ofs(input int idx);
    case (idx)
      A_VAL:   attr_ofs = 7'h00;
      A_OE:    attr_ofs = 7'h04;
      A_OD:    attr_ofs = 7'h08;
      A_OINV:  attr_ofs = 7'h0C;
      A_PU:    attr_ofs = 7'h18;
      A_PD:    attr_ofs = 7'h1C;
      A_IE:    attr_ofs = 7'h20;
      default: attr_ofs = 7'h24;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
  import gpio_sc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [OFS_W-1:0]          ofs_i,
  input  logic [2*W-1:0]            wdata_i,
  output logic [NATTR-1:0][W-1:0]   attr_o,
  output logic [W-1:0]              rd_o
);
  logic [NATTR-1:0][W-1:0] attr_q;
  logic [W-1:0] set_m, clr_m;

  assign set_m = wdata_i[W-1:0];
  assign clr_m = wdata_i[2*W-1:W];

  for (genvar a = 0; a < NATTR; a++) begin : g_attr
    logic hit;
    assign hit = wr_i && (ofs_i == attr_ofs(a));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  attr_q[a] <= '0;
      else if (hit) attr_q[a] <= (attr_q[a] | set_m) & ~clr_m; // clear wins
    end
  end

  always_comb begin
    rd_o = '0;
    for (int a = 0; a < NATTR; a++)
      if (ofs_i == attr_ofs(a)) rd_o = attr_q[a];
  end

  assign attr_o = attr_q;
endmodule

// File: rtl/gpio_sc_pad.sv
module gpio_sc_pad (
  input  logic val_i,
  input  logic oe_i,
  input  logic od_i,
  input  logic oinv_i,
  input  logic ie_i,
  input  logic iinv_i,
  input  logic pad_in_i,
  output logic pad_out_o,
  output logic pad_oe_o,
  output logic in_val_o
);
  logic drv;
  assign drv = val_i ^ oinv_i;

  always_comb begin
    pad_out_o = 1'b0;
    pad_oe_o  = 1'b0;
    if (oe_i) begin
      if (od_i) begin
        pad_oe_o = ~drv;          // pull low only, release for 1
      end else begin
        pad_oe_o  = 1'b1;
        pad_out_o = drv;
      end
    end
  end

  assign in_val_o = ie_i & (pad_in_i ^ iinv_i);
endmodule

// File: rtl/gpio_sc_ctrl.sv
module gpio_sc_ctrl
  import gpio_sc_pkg::*;
#(
  parameter int BANK_W = 16,
  parameter int NPINS  = 32,
  parameter int AW     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [2*BANK_W-1:0] wdata_i,
  output logic [2*BANK_W-1:0] rdata_o,
  input  logic [NPINS-1:0]    pad_in_i,
  output logic [NPINS-1:0]    pad_out_o,
  output logic [NPINS-1:0]    pad_oe_o,
  output logic [NPINS-1:0]    pad_pu_o,
  output logic [NPINS-1:0]    pad_pd_o,
  output logic [NPINS-1:0]    in_val_o
);
  localparam int NBANK  = NPINS / BANK_W;
  localparam int BSEL_W = AW - OFS_W;

  logic [BSEL_W-1:0] bank_sel;
  logic [OFS_W-1:0]  ofs;
  logic [NBANK-1:0][BANK_W-1:0] bank_rd;
  logic [NATTR-1:0][NPINS-1:0]  attr_full;

  assign bank_sel = addr_i[AW-1:OFS_W];
  assign ofs      = addr_i[OFS_W-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NATTR-1:0][BANK_W-1:0] battr;
    gpio_sc_bank #(.W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && (bank_sel == BSEL_W'(b))),
      .ofs_i   (ofs),
      .wdata_i (wdata_i),
      .attr_o  (battr),
      .rd_o    (bank_rd[b])
    );
    for (genvar a = 0; a < NATTR; a++) begin : g_map
      assign attr_full[a][b*BANK_W +: BANK_W] = battr[a];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++)
      if (bank_sel == BSEL_W'(b)) rdata_o[BANK_W-1:0] = bank_rd[b];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_sc_pad u_pad (
      .val_i     (attr_full[A_VAL][p]),
      .oe_i      (attr_full[A_OE][p]),
      .od_i      (attr_full[A_OD][p]),
      .oinv_i    (attr_full[A_OINV][p]),
      .ie_i      (attr_full[A_IE][p]),
      .iinv_i    (attr_full[A_IINV][p]),
      .pad_in_i  (pad_in_i[p]),
      .pad_out_o (pad_out_o[p]),
      .pad_oe_o  (pad_oe_o[p]),
      .in_val_o  (in_val_o[p])
    );
  end

  assign pad_pu_o = attr_full[A_PU];
  assign pad_pd_o = attr_full[A_PD];
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [31:0]      wdata_i,
  input logic [NPINS-1:0] pad_out_o,
  input logic [NPINS-1:0] pad_oe_o,
  input logic [NPINS-1:0] in_val_o,
  input logic [NPINS-1:0] val_i,
  input logic [NPINS-1:0] oe_i,
  input logic [NPINS-1:0] od_i,
  input logic [NPINS-1:0] oinv_i,
  input logic [NPINS-1:0] pu_i,
  input logic [NPINS-1:0] pd_i,
  input logic [NPINS-1:0] ie_i,
  input logic [NPINS-1:0] iinv_i
);
  logic low_val_wr;
  assign low_val_wr = we_i && (addr_i == 8'h00);

  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_val_wr |=> ((val_i[15:0] & ($past(wdata_i[15:0]) & ~$past(wdata_i[31:16])))
                    == ($past(wdata_i[15:0]) & ~$past(wdata_i[31:16]))));

  assert_clear_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_val_wr |=> ((val_i[15:0] & $past(wdata_i[31:16])) == 16'h0)); // also R3

  assert_unmapped_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[6:0] >= 7'h28) |=>
      ($stable(val_i) && $stable(oe_i) && $stable(od_i) && $stable(oinv_i) &&
       $stable(pu_i) && $stable(pd_i) && $stable(ie_i) && $stable(iinv_i)));

  assert_od_never_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & od_i) == '0);

  assert_no_drive_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~oe_i) == '0);

  assert_input_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_val_o & ~ie_i) == '0);
endmodule

bind gpio_sc_ctrl gpio_sc_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .in_val_o  (in_val_o),
  .val_i     (attr_full[gpio_sc_pkg::A_VAL]),
  .oe_i      (attr_full[gpio_sc_pkg::A_OE]),
  .od_i      (attr_full[gpio_sc_pkg::A_OD]),
  .oinv_i    (attr_full[gpio_sc_pkg::A_OINV]),
  .pu_i      (attr_full[gpio_sc_pkg::A_PU]),
  .pd_i      (attr_full[gpio_sc_pkg::A_PD]),
  .ie_i      (attr_full[gpio_sc_pkg::A_IE]),
  .iinv_i    (attr_full[gpio_sc_pkg::A_IINV])
);

// File: tb/gpio_sc_ctrl_tb.sv
module gpio_sc_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_in, pad_out, pad_oe, pad_pu, pad_pd, in_val;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  gpio_sc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pu_o(pad_pu), .pad_pd_o(pad_pd), .in_val_o(in_val)
  );

  // {addr, write word, expected readback of that address}
  localparam int NVEC = 14;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h00, 32'h0000_0005, 32'h0000_0005},  // R2 set
    {8'h00, 32'h0004_0002, 32'h0000_0003},  // R3 clear bit2, set bit1
    {8'h00, 32'h0001_0001, 32'h0000_0002},  // R4 set+clear bit0
    {8'h80, 32'h0000_8001, 32'h0000_8001},  // R5 high bank
    {8'h04, 32'h0000_00FF, 32'h0000_00FF},  // R6 offsets
    {8'h08, 32'h0000_0003, 32'h0000_0003},
    {8'h0C, 32'h0000_0010, 32'h0000_0010},
    {8'h18, 32'h0000_F000, 32'h0000_F000},
    {8'h1C, 32'h0000_0F00, 32'h0000_0F00},
    {8'h20, 32'h0000_FFFF, 32'h0000_FFFF},
    {8'h24, 32'h0000_00F0, 32'h0000_00F0},
    {8'h84, 32'hFFFF_0000, 32'h0000_0000},
    {8'h30, 32'h0000_FFFF, 32'h0000_0000},  // R7 unmapped
    {8'h84, 32'h0000_8001, 32'h0000_8001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    pad_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 val", 8'h00, 32'h0);
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 out", pad_out, 32'h0);
    chk("R1 in", in_val, 32'h0);
    chk("R1 pu", pad_pu | pad_pd, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd_chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d", i), VEC[i][71:64], VEC[i][31:0]);
    end

    rd_chk("R7 ie kept", 8'h20, 32'h0000_FFFF);
    rd_chk("R7 read 0x10", 8'h10, 32'h0);
    rd_chk("R5 low val intact", 8'h00, 32'h0000_0002);

    // pads: drive = val^oinv low 0x0012, high 0x8001
    pad_in = 32'h1234_5678;
    #1;
    chk("R8/R9 pad_oe", pad_oe, 32'h8001_00FD);
    chk("R8/R9 pad_out", pad_out, 32'h8001_0010);
    chk("R11 pu", pad_pu, 32'h0000_F000);
    chk("R11 pd", pad_pd, 32'h0000_0F00);
    chk("R12 in_val", in_val, 32'h0000_5688);

    wr(8'h04, 32'hFFFF_0000);
    #1;
    chk("R10 pad_oe", pad_oe, 32'h8001_0000);
    chk("R10 pad_out", pad_out, 32'h8001_0000);

    wr(8'hA0, 32'h0000_00FF);
    #1;
    chk("R12 high ie", in_val, 32'h0034_5688);

    // R1 asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    rd_chk("R1 async val", 8'h80, 32'h0);
    chk("R1 async oe", pad_oe, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule